// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one register that exists as several per-unit copies, one for each hardware unit in a grid of groups and instances, all answering at a single bus address. A separate steering register picks which copy a unicast access reaches, and carries a broadcast flag that makes a write land in every copy at once. Reads always come from exactly one copy, the steered one, whatever the broadcast flag holds.

Each copy has a presence input driven by fuse and power logic outside the block. A copy whose presence bit is low counts as terminated. Writes to it are dropped without any error, and reads steered to it return zero. Software first programs the steering register and then accesses the shared address. At reset the broadcast flag is set, so a plain write reaches every live copy.

Top module: `repbank_top`

## Requirements
- R1: After reset the steering register reads 0x8000_0000 (broadcast set, group 0, instance 0), every copy holds zero and busRvalid is low.
- R2: The steering register at address 0 keeps group in bits 1:0, instance in bits 9:8 and the broadcast flag in bit 31. It reads back those fields as last written, and all other bits read zero.
- R3: With broadcast set, a write to the shared address (address 1) stores the write data in every present copy.
- R4: A broadcast write leaves every terminated copy unchanged.
- R5: With broadcast clear, a write to the shared address changes only the copy at unit index group*4+instance, and all other copies keep their values.
- R6: A unicast write steered to a terminated copy is ignored, and that copy keeps its old value.
- R7: A read of the shared address returns the copy chosen by group and instance, whether the broadcast flag is set or clear.
- R8: A read steered to a terminated copy returns zero.
- R9: Read data and a one-cycle busRvalid pulse appear one clock after a read request. Writes never raise busRvalid.
- R10: A read of any address other than 0 or 1 returns zero, and a write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| unitPresent | input | 16 | Presence per copy, bit index group*4+instance |
| busRdata | output | 32 | Read data, held until the next read |
| busRvalid | output | 1 | Read data valid pulse |

## Verification
A write updates its target copy or the steering register at the clock edge that samples the request, so its effect can be seen through a read issued on the next cycle. Read data and busRvalid are registered once and are due one edge after the request. The bench drives each request on a falling edge and samples results on the following falling edge, half a period after the update. Effects on terminated copies are checked at the ports: presence is restored and the copy is read back.

// File: rtl/repbank_pkg.sv
package repbank_pkg;
  // bit position of the instance field inside the steering register
  localparam int INST_LSB = 8;

  typedef struct packed {
    logic selWr;
    logic selRd;
    logic repWrAll;
    logic repWrOne;
    logic repRd;
    logic nullRd;
  } strobe_t;
endpackage

// File: rtl/repbank_ctrl.sv
module repbank_ctrl
  import repbank_pkg::*;
#(
  parameter int GROUPS   = 4,
  parameter int INSTS    = 4,
  parameter int DW       = 32,
  parameter int AW       = 4,
  parameter int SEL_ADDR = 0,
  parameter int REP_ADDR = 1,
  localparam int GW = $clog2(GROUPS),
  localparam int IW = $clog2(INSTS),
  localparam int NU = GROUPS * INSTS,
  localparam int UW = $clog2(NU)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busEn,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output strobe_t       stb,
  output logic [UW-1:0] unitIdx,
  output logic [DW-1:0] selVal,
  output logic          rvalid
);
  logic [GW-1:0] grpQ;
  logic [IW-1:0] instQ;
  logic          mcastQ;

  logic selHit, repHit;
  assign selHit = (busAddr == AW'(SEL_ADDR));
  assign repHit = (busAddr == AW'(REP_ADDR));

  always_comb begin
    stb          = '0;
    stb.selWr    = busEn && busWr && selHit;
    stb.selRd    = busEn && !busWr && selHit;
    stb.repWrAll = busEn && busWr && repHit && mcastQ;
    stb.repWrOne = busEn && busWr && repHit && !mcastQ;
    stb.repRd    = busEn && !busWr && repHit;
    stb.nullRd   = busEn && !busWr && !selHit && !repHit;
  end

  assign unitIdx = UW'(int'(grpQ) * INSTS + int'(instQ));

  always_comb begin
    selVal                  = '0;
    selVal[GW-1:0]          = grpQ;
    selVal[INST_LSB +: IW]  = instQ;
    selVal[DW-1]            = mcastQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpQ   <= '0;
      instQ  <= '0;
      mcastQ <= 1'b1;
    end else if (stb.selWr) begin
      grpQ   <= busWdata[GW-1:0];
      instQ  <= busWdata[INST_LSB +: IW];
      mcastQ <= busWdata[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rvalid <= 1'b0;
    else       rvalid <= busEn && !busWr;
  end

  // R9
  rvalid_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWr) |=> rvalid);
  // R9
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busEn && !busWr) |=> !rvalid);
  // R2
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.selWr |=> (selVal[DW-1] == $past(busWdata[DW-1])));
endmodule

// File: rtl/repbank_dp.sv
module repbank_dp
  import repbank_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int INSTS  = 4,
  parameter int DW     = 32,
  localparam int NU = GROUPS * INSTS,
  localparam int UW = $clog2(NU)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [UW-1:0] unitIdx,
  input  logic [DW-1:0] selVal,
  input  logic [DW-1:0] wdata,
  input  logic [NU-1:0] unitPresent,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] copyQ [NU];

  for (genvar k = 0; k < NU; k++) begin : g_copy
    logic hitMe;
    assign hitMe = unitPresent[k] &&
                   (stb.repWrAll || (stb.repWrOne && unitIdx == UW'(k)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      copyQ[k] <= '0;
      else if (hitMe) copyQ[k] <= wdata;
    end

    // R3
    mc_update_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.repWrAll && unitPresent[k]) |=> (copyQ[k] == $past(wdata)));
    // R4
    mc_skip_dead_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.repWrAll && !unitPresent[k]) |=> $stable(copyQ[k]));
    // R5
    uc_other_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.repWrOne && unitIdx != UW'(k)) |=> $stable(copyQ[k]));
    // R6
    uc_dead_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.repWrOne && !unitPresent[k]) |=> $stable(copyQ[k]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (stb.selRd)   rdData <= selVal;
    else if (stb.repRd)   rdData <= unitPresent[unitIdx] ? copyQ[unitIdx] : '0;
    else if (stb.nullRd)  rdData <= '0;
  end

  // R8
  dead_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.repRd && !unitPresent[unitIdx]) |=> (rdData == '0));
  // R10
  null_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.nullRd |=> (rdData == '0));
endmodule

// File: rtl/repbank_top.sv
module repbank_top
  import repbank_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int INSTS  = 4,
  parameter int DW     = 32,
  parameter int AW     = 4,
  localparam int NU = GROUPS * INSTS,
  localparam int UW = $clog2(NU)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busEn,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic [NU-1:0] unitPresent,
  output logic [DW-1:0] busRdata,
  output logic          busRvalid
);
  strobe_t       stb;
  logic [UW-1:0] unitIdx;
  logic [DW-1:0] selVal;

  repbank_ctrl #(.GROUPS(GROUPS), .INSTS(INSTS), .DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .stb(stb), .unitIdx(unitIdx), .selVal(selVal),
    .rvalid(busRvalid)
  );

  repbank_dp #(.GROUPS(GROUPS), .INSTS(INSTS), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .unitIdx(unitIdx), .selVal(selVal),
    .wdata(busWdata), .unitPresent(unitPresent), .rdData(busRdata)
  );
endmodule

// File: tb/sim_repbank_top.sv
`timescale 1ns/100ps
module sim_repbank_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [15:0] unitPresent = 16'hFFFF;
  logic [31:0] busRdata;
  logic        busRvalid;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  repbank_top u0 (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .unitPresent(unitPresent), .busRdata(busRdata),
    .busRvalid(busRvalid)
  );

  // vector: {wr, addr, data, expected read}
  localparam int NV = 13;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 4'd0, 32'h8000_0000, 32'h0},           // broadcast on
    {1'b1, 4'd1, 32'hA5A5_0001, 32'h0},           // R3 all copies
    {1'b0, 4'd0, 32'h0,         32'h8000_0000},   // R2
    {1'b1, 4'd0, 32'h0000_0102, 32'h0},           // g2 i1 unicast
    {1'b1, 4'd1, 32'h1234_5678, 32'h0},           // R5
    {1'b0, 4'd1, 32'h0,         32'h1234_5678},   // R5 R7
    {1'b1, 4'd0, 32'h0000_0000, 32'h0},           // g0 i0
    {1'b0, 4'd1, 32'h0,         32'hA5A5_0001},   // R3 R5 other copy
    {1'b1, 4'd0, 32'hFFFF_FFFF, 32'h0},           // g3 i3 broadcast
    {1'b0, 4'd0, 32'h0,         32'h8000_0303},   // R2 masked
    {1'b0, 4'd1, 32'h0,         32'hA5A5_0001},   // R7 with broadcast set
    {1'b1, 4'd5, 32'h0000_DEAD, 32'h0},           // R10 unmapped write
    {1'b0, 4'd5, 32'h0,         32'h0}            // R10 unmapped read
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic op(input logic wr, input logic [3:0] a, input logic [31:0] d,
                    output logic [31:0] rd, output logic rv);
    busEn = 1'b1; busWr = wr; busAddr = a; busWdata = d;
    @(negedge clk);
    rd = busRdata; rv = busRvalid;
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] rd;
    logic rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rvalid", {31'b0, busRvalid}, 32'h0);
    op(1'b0, 4'd0, 32'h0, rd, rv);
    check("R1 selector", rd, 32'h8000_0000);
    op(1'b0, 4'd1, 32'h0, rd, rv);
    check("R1 copy", rd, 32'h0);
    check("R9 read valid", {31'b0, rv}, 32'h1);
    @(negedge clk);
    check("R9 single pulse", {31'b0, busRvalid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][68], VEC[i][67:64], VEC[i][63:32], rd, rv);
      if (VEC[i][68]) check("R9 write no valid", {31'b0, rv}, 32'h0);
      else            check($sformatf("vec%0d R2/R3/R5/R7/R10", i), rd, VEC[i][31:0]);
    end

    // terminated copy g1 i2 -> unit 6
    op(1'b1, 4'd0, 32'h8000_0000, rd, rv);
    unitPresent = 16'hFFFF & ~16'h0040;
    op(1'b1, 4'd1, 32'h0000_7777, rd, rv);
    op(1'b1, 4'd0, 32'h0000_0201, rd, rv);   // g1 i2 unicast
    op(1'b0, 4'd1, 32'h0, rd, rv);
    check("R8 dead read", rd, 32'h0);
    op(1'b1, 4'd1, 32'h0000_BEEF, rd, rv);   // R6 dropped
    unitPresent = 16'hFFFF;
    op(1'b0, 4'd1, 32'h0, rd, rv);
    check("R4 R6 dead copy kept", rd, 32'hA5A5_0001);
    op(1'b1, 4'd0, 32'h0000_0003, rd, rv);   // g3 i0
    op(1'b0, 4'd1, 32'h0, rd, rv);
    check("R3 live copy broadcast", rd, 32'h0000_7777);
    op(1'b1, 4'd1, 32'h0000_4242, rd, rv);
    op(1'b0, 4'd1, 32'h0, rd, rv);
    check("R5 unicast live", rd, 32'h0000_4242);
    op(1'b0, 4'd0, 32'h0, rd, rv);
    check("R2 readback", rd, 32'h0000_0003);
    finish();
  end
endmodule